// File: doc/BRIEF.md
# Processor Power-Tuning Register Unit

This block stands in for the power-tuning control point of a processor core. Software or a controller writes 32-bit words into a two-half control register through a synchronous write port. The top bit of each word picks which half is written. When a word goes to the low half with its frequency-request flag set, the unit runs a speed change. It raises a "received" indication, waits a configurable settle time, and then applies the requested ratio. Finally it swaps "received" for "completed".

Progress and the ratio currently in effect are reported in a 64-bit status word. That word is read through a registered read port at its own address. The ratio in effect is also driven on a dedicated output. Only the full-speed and half-speed ratios can take effect. A request for quarter speed, or for any other code, completes the handshake but leaves the ratio as it was. Writing zero into both halves withdraws a pending change and clears the completed flag.

Top module: `pwr_tune_ctrl`

## Requirements
- R1: After reset, `cur_speed` is 0 (full speed), both control halves read as zero, and the status word is zero.
- R2: A write to address 0x0aa001 stores bits 30:0 of the data into the low half when data bit 31 is 1, and into the high half when bit 31 is 0. A read of 0x0aa001 returns the high half in bits 62:32 and the low half in bits 30:0; bits 63 and 31 read as 0.
- R3: A low-half write with data bit 16 set, made while no change is running, sets status bit 61 (received) and clears bit 60 (completed) from the next cycle. Bit 61 stays set for exactly SETTLE_CYC cycles.
- R4: In the cycle that received drops, completed sets. If the speed field (data bits 19:17) was 0 or 1, `cur_speed` takes that value. Status bits 57:56 always mirror `cur_speed`.
- R5: A speed field of 2 (quarter) or of 3 to 7 still ends with completed set, but `cur_speed` is left unchanged. `cur_speed` never holds a value other than 0 or 1.
- R6: A high-half write, a low-half write with bit 16 clear, or any write to another address starts no change.
- R7: A start request made while a change is running is ignored. The running change keeps its target and its timing.
- R8: A control write that leaves both halves zero clears received and completed. It also abandons a running change, so `cur_speed` is kept.
- R9: Read data appears one cycle after `rd_en`. A read of any address other than 0x0aa001 or 0x408001 returns zero.
- R10: Received and completed are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 24 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 24 | Read address |
| rd_data | output | 64 | Registered read data |
| cur_speed | output | 2 | Ratio in effect: 0 full, 1 half |

## Verification
The hardest case to reach is a second start, or a clear, landing while a change is still settling. Only an exact sequence of back-to-back writes places one inside the settle window. The bench uses a settle time of five cycles so that a start, two writes and a clear all fit inside one window. It counts negative edges from the first write to decide whether the second write arrived early enough. It also sweeps all eight speed codes from both starting ratios, and the final ratio shows whether a restart or an abort took effect.

// File: rtl/pwr_tune_pkg.sv
package pwr_tune_pkg;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int STAT_W = 64;
  localparam int HALF_W = 31;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 24'h0aa001;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 24'h408001;

  localparam int SEL_BIT    = 31;
  localparam int FREQ_VLD   = 16;
  localparam int SPD_LSB    = 17;
  localparam int SPD_W      = 3;
  localparam int RECV_BIT   = 61;
  localparam int CMPL_BIT   = 60;
  localparam int CUR_LSB    = 56;

  typedef logic [1:0]       speed_t;
  typedef logic [SPD_W-1:0] spd_code_t;

  localparam speed_t SPD_FULL = 2'd0;
  localparam speed_t SPD_HALF = 2'd1;

  typedef struct packed {
    logic [HALF_W-1:0] hi;
    logic [HALF_W-1:0] lo;
  } ctrl_pair_t;

  function automatic spd_code_t speed_field(input logic [DATA_W-1:0] d);
    return d[SPD_LSB +: SPD_W];
  endfunction

  function automatic logic speed_supported(input spd_code_t c);
    return (c == spd_code_t'(SPD_FULL)) || (c == spd_code_t'(SPD_HALF));
  endfunction

  function automatic speed_t resolve_speed(input speed_t cur, input spd_code_t c);
    return speed_supported(c) ? speed_t'(c) : cur;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input logic recv,
                                                    input logic cmpl,
                                                    input speed_t cur);
    logic [STAT_W-1:0] w;
    w = '0;
    w[RECV_BIT] = recv;
    w[CMPL_BIT] = cmpl;
    w[CUR_LSB +: 2] = cur;
    return w;
  endfunction

  function automatic logic [STAT_W-1:0] pack_ctrl(input ctrl_pair_t p);
    return {1'b0, p.hi, 1'b0, p.lo};
  endfunction

endpackage

// File: rtl/pcr_write_decode.sv
module pcr_write_decode
  import pwr_tune_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_pair_t        pair_o,
  output logic              start_o,
  output logic              clear_o,
  output spd_code_t         tgt_o
);

  ctrl_pair_t pair_q;
  logic       hit, to_lo, to_hi;
  logic [HALF_W-1:0] nxt_hi, nxt_lo;

  assign hit    = wr_en && (wr_addr == CTRL_ADDR);
  assign to_lo  = hit && wr_data[SEL_BIT];
  assign to_hi  = hit && !wr_data[SEL_BIT];
  assign nxt_hi = to_hi ? wr_data[HALF_W-1:0] : pair_q.hi;
  assign nxt_lo = to_lo ? wr_data[HALF_W-1:0] : pair_q.lo;

  assign start_o = to_lo && wr_data[FREQ_VLD];
  assign clear_o = hit && (nxt_hi == '0) && (nxt_lo == '0);
  assign tgt_o   = speed_field(wr_data);
  assign pair_o  = pair_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pair_q <= '0;
    end else begin
      pair_q.hi <= nxt_hi;
      pair_q.lo <= nxt_lo;
    end
  end

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_o |=> (pair_q == '0));

  assert_hi_write_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[SEL_BIT]) |-> !start_o);

endmodule

// File: rtl/speed_sequencer.sv
module speed_sequencer
  import pwr_tune_pkg::*;
#(
  parameter int SETTLE_CYC = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      clear_i,
  input  spd_code_t tgt_i,
  output logic      recv_o,
  output logic      cmpl_o,
  output speed_t    cur_o
);

  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

  typedef enum logic {ST_IDLE, ST_SETTLE} seq_state_t;

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  spd_code_t        tgt_q;
  logic             recv_q, cmpl_q;
  speed_t           cur_q;
  logic             accept, finish;

  assign accept = start_i && (state_q == ST_IDLE) && !clear_i;
  assign finish = (state_q == ST_SETTLE) && (cnt_q == LAST) && !clear_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tgt_q   <= '0;
      recv_q  <= 1'b0;
      cmpl_q  <= 1'b0;
      cur_q   <= SPD_FULL;
    end else if (clear_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      recv_q  <= 1'b0;
      cmpl_q  <= 1'b0;
    end else if (accept) begin
      state_q <= ST_SETTLE;
      cnt_q   <= '0;
      tgt_q   <= tgt_i;
      recv_q  <= 1'b1;
      cmpl_q  <= 1'b0;
    end else if (finish) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      recv_q  <= 1'b0;
      cmpl_q  <= 1'b1;
      cur_q   <= resolve_speed(cur_q, tgt_q);
    end else if (state_q == ST_SETTLE) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign recv_o = recv_q;
  assign cmpl_o = cmpl_q;
  assign cur_o  = cur_q;

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(recv_q && cmpl_q));

  assert_speed_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q <= SPD_HALF);

  assert_speed_moves_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_q) |-> $rose(cmpl_q));

  assert_recv_from_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recv_q) |-> $past(start_i));

  assert_recv_drop_completes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(recv_q) && !$past(clear_i)) |-> cmpl_q);

  assert_busy_keeps_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(recv_q) && recv_q) |-> (tgt_q == $past(tgt_q)));

  assert_clear_drops_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear_i) |-> (!recv_q && !cmpl_q));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/status_read_port.sv
module status_read_port
  import pwr_tune_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  ctrl_pair_t        pair_i,
  input  logic              recv_i,
  input  logic              cmpl_i,
  input  speed_t            cur_i,
  output logic [STAT_W-1:0] rd_data
);

  logic [STAT_W-1:0] rd_q, rd_nxt;
  logic              mapped;

  assign mapped = (rd_addr == CTRL_ADDR) || (rd_addr == STAT_ADDR);

  always_comb begin
    rd_nxt = '0;
    if (rd_addr == CTRL_ADDR)      rd_nxt = pack_ctrl(pair_i);
    else if (rd_addr == STAT_ADDR) rd_nxt = pack_status(recv_i, cmpl_i, cur_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_nxt;
  end

  assign rd_data = rd_q;

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en) && !$past(mapped)) |-> (rd_q == '0));

  assert_speed_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en) && $past(rd_addr) == STAT_ADDR) |-> (rd_q[CUR_LSB +: 2] == $past(cur_i)));

endmodule

// File: rtl/pwr_tune_ctrl.sv
module pwr_tune_ctrl
  import pwr_tune_pkg::*;
#(
  parameter int SETTLE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [STAT_W-1:0] rd_data,
  output logic [1:0]        cur_speed
);

  ctrl_pair_t pair;
  logic       start_req, clear_req, recv, cmpl;
  spd_code_t  tgt_code;
  speed_t     cur;

  pcr_write_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pair_o  (pair),
    .start_o (start_req),
    .clear_o (clear_req),
    .tgt_o   (tgt_code)
  );

  speed_sequencer #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_req),
    .clear_i (clear_req),
    .tgt_i   (tgt_code),
    .recv_o  (recv),
    .cmpl_o  (cmpl),
    .cur_o   (cur)
  );

  status_read_port u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .pair_i  (pair),
    .recv_i  (recv),
    .cmpl_i  (cmpl),
    .cur_i   (cur),
    .rd_data (rd_data)
  );

  assign cur_speed = cur;

  assert_start_needs_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> (wr_en && wr_addr == CTRL_ADDR && wr_data[FREQ_VLD]));

endmodule

// File: tb/test_pwr_tune_ctrl.sv
`timescale 1ns/1ps
module test_pwr_tune_ctrl;

  localparam int S = 5;
  localparam logic [23:0] A_CTRL = 24'h0aa001;
  localparam logic [23:0] A_STAT = 24'h408001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [23:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b1;
  logic [23:0] rd_addr = A_STAT;
  logic [63:0] rd_data;
  logic [1:0]  cur_speed;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pwr_tune_ctrl #(.SETTLE_CYC(S)) i_pwr_tune_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .cur_speed(cur_speed)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, output logic [63:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
    rd_addr = A_STAT;
  endtask

  // Observes the status word for n cycles after a write.
  task automatic watch(input int n, output int nrecv, output int first_cmpl,
                       output logic [1:0] last_spd, output logic last_cmpl);
    nrecv = 0; first_cmpl = 0; last_spd = 2'd0; last_cmpl = 1'b0;
    for (int j = 1; j <= n; j++) begin
      @(negedge clk);
      if (rd_data[61]) nrecv++;
      if (rd_data[60] && first_cmpl == 0) first_cmpl = j;
      last_spd  = rd_data[57:56];
      last_cmpl = rd_data[60];
    end
  endtask

  function automatic logic [31:0] start_word(input int code);
    return 32'h8001_0000 | (32'(code) << 17);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d;
    int nr, fc;
    logic [1:0] ls;
    logic lc;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(cur_speed == 2'd0, "R1 speed", cur_speed, 0);
    chk(rd_data == 64'd0, "R1 status", rd_data, 0);
    rd(A_CTRL, d);
    chk(d == 64'd0, "R1 ctrl", d, 0);

    // R2 half select and readback
    wr(A_CTRL, 32'h8002_0F35);
    wr(A_CTRL, 32'h1234_5678);
    rd(A_CTRL, d);
    chk(d == {32'h1234_5678, 32'h0002_0F35}, "R2 readback", d, {32'h1234_5678, 32'h0002_0F35});
    wr(A_CTRL, 32'hFFFE_FFFF);
    rd(A_CTRL, d);
    chk(d == {32'h1234_5678, 32'h7FFE_FFFF}, "R2 bit31 masked", d, {32'h1234_5678, 32'h7FFE_FFFF});

    // R9 unmapped reads
    rd(24'h000123, d);
    chk(d == 64'd0, "R9 unmapped", d, 0);
    rd(24'h408000, d);
    chk(d == 64'd0, "R9 near status", d, 0);

    // R6 writes that must not start
    wr(A_CTRL, 32'h0003_0000);
    watch(S + 3, nr, fc, ls, lc);
    chk(nr == 0, "R6 high half", nr, 0);
    wr(A_CTRL, 32'h8002_0000);
    watch(S + 3, nr, fc, ls, lc);
    chk(nr == 0, "R6 no valid bit", nr, 0);
    wr(24'h0aa002, start_word(1));
    watch(S + 3, nr, fc, ls, lc);
    chk(nr == 0 && cur_speed == 2'd0, "R6 other address", nr, 0);

    // R3 R4 R5 sweep of all codes from both starting ratios
    for (int s0 = 0; s0 < 2; s0++) begin
      for (int code = 0; code < 8; code++) begin
        logic [1:0] exp_spd;
        wr(A_CTRL, start_word(s0));
        watch(S + 3, nr, fc, ls, lc);
        exp_spd = (code <= 1) ? 2'(code) : 2'(s0);
        wr(A_CTRL, start_word(code));
        watch(S + 3, nr, fc, ls, lc);
        chk(nr == S, "R3 received length", nr, S);
        chk(fc == S + 1, "R4 completion cycle", fc, S + 1);
        chk(lc == 1'b1, "R5 completed set", lc, 1);
        chk(cur_speed == exp_spd, "R5 speed result", cur_speed, exp_spd);
        chk(ls == exp_spd, "R4 status speed", ls, exp_spd);
      end
    end

    // R7 start while busy is ignored (speed is 1 here, go to 0 then try 1)
    wr(A_CTRL, start_word(0));
    watch(S + 3, nr, fc, ls, lc);
    wr(A_CTRL, start_word(1));
    @(negedge clk);
    wr(A_CTRL, start_word(0));
    repeat (S) @(negedge clk);
    chk(cur_speed == 2'd1, "R7 first target", cur_speed, 1);
    repeat (S + 3) @(negedge clk);
    chk(cur_speed == 2'd1, "R7 no restart", cur_speed, 1);

    // R8 abort a running change by zeroing both halves
    wr(A_CTRL, 32'h0000_0000);
    wr(A_CTRL, start_word(0));
    wr(A_CTRL, 32'h8000_0000);
    watch(2, nr, fc, ls, lc);
    chk(rd_data[61:60] == 2'b00, "R8 flags cleared", rd_data[61:60], 0);
    repeat (S + 2) @(negedge clk);
    chk(cur_speed == 2'd1, "R8 speed kept", cur_speed, 1);
    chk(rd_data[61:60] == 2'b00, "R8 stays idle", rd_data[61:60], 0);

    // R8 clear of a completed flag
    wr(A_CTRL, start_word(0));
    watch(S + 3, nr, fc, ls, lc);
    chk(lc == 1'b1 && cur_speed == 2'd0, "R4 done before clear", cur_speed, 0);
    wr(A_CTRL, 32'h8000_0000);
    watch(2, nr, fc, ls, lc);
    chk(lc == 1'b0 && nr == 0, "R8 completed cleared", lc, 0);
    chk(ls == 2'd0, "R10 speed after clear", ls, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule